// File: doc/BRIEF.md
# Width-Selectable Decrement Unit with Flag Generation

This block takes an operand, subtracts one from it at a selected width (8, 16, 32 or 64 bits), and produces the truncated result together with an updated status-flag word. The carry bit of the flag word is passed through unchanged. The overflow, sign, zero, auxiliary-carry and parity bits are recomputed from the result. All other flag bits are passed through untouched.

The datapath is purely combinational up to one output register stage. Every output, including the valid strobe, appears on the clock edge after the input is presented. The surrounding pipeline fetches the operand and writes the result back; this block does neither.

Top module: `dec_unit`

## Requirements
- R1: `result` equals `operand` minus one, modulo 2^w. The width w is chosen by `size_sel`: 2'b00 selects 8, 2'b01 selects 16, 2'b10 selects 32 and 2'b11 selects 64.
- R2: Flag bit 0 (carry) of `flags_out` equals bit 0 of `flags_in`, for every operand value.
- R3: Flag bit 11 (overflow) is set exactly when the operand, taken at width w, equals 2^(w-1), the most negative signed value.
- R4: Flag bit 7 (sign) equals bit w-1 of the result.
- R5: Flag bit 6 (zero) is set exactly when the operand, taken at width w, equals 1.
- R6: Flag bit 4 (auxiliary carry) is set exactly when operand bits [3:0] are all zero, which is a borrow out of bit 3.
- R7: Flag bit 2 (parity) is set exactly when result bits [7:0] hold an even number of ones, at every width.
- R8: For widths below 64, result bits at and above w are zero, and operand bits at and above w have no effect on the result or on any flag.
- R9: Flag bits other than 0, 2, 4, 6, 7 and 11 equal the same bits of `flags_in`.
- R10: `out_valid` equals `in_valid` from one clock earlier. While `rst_n` is low, `out_valid`, `result` and `flags_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| size_sel | input | 2 | Operand width select |
| operand | input | 64 | Value to decrement |
| flags_in | input | 16 | Incoming status-flag word |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| result | output | 64 | Decremented value at the selected width |
| flags_out | output | 16 | Updated status-flag word |

## Verification
The hardest cases to reach are those where the bits above the selected width differ from the bits inside it. One example is an 8-bit operand of 0x01 carrying garbage in its upper bits, which must still set the zero flag. Another is a value that is the most negative number at one width but an ordinary value at a wider one. To reach these, the stimulus takes each boundary pattern (0, 1, 2, the most negative value, its predecessor, all ones, 0x10) at every width. It applies each pattern both with clean upper bits and with pseudo-random upper bits. It also sets the incoming flag word to both all-ones and random values, so that a flag accidentally forced or cleared is exposed. Random operands, widths and valid gaps then fill in between these cases.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int DATA_W  = 64;
    localparam int FLAG_W  = 16;
    localparam int NSIZES  = 4;
    localparam int SIZE_W  = $clog2(NSIZES);

    // flag bit positions within the status word
    localparam int FB_CARRY = 0;
    localparam int FB_PAR   = 2;
    localparam int FB_AUX   = 4;
    localparam int FB_ZERO  = 6;
    localparam int FB_SIGN  = 7;
    localparam int FB_OVF   = 11;

    localparam logic [FLAG_W-1:0] FLAG_RECALC =
        FLAG_W'((1 << FB_PAR) | (1 << FB_AUX) | (1 << FB_ZERO) |
                (1 << FB_SIGN) | (1 << FB_OVF));

    typedef enum logic [SIZE_W-1:0] {
        SZ_B8  = 2'b00,
        SZ_B16 = 2'b01,
        SZ_B32 = 2'b10,
        SZ_B64 = 2'b11
    } dec_size_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] flg;
    } dec_stage_t;
endpackage

// File: rtl/dec_width_mask.sv
module dec_width_mask
    import dec_pkg::*;
(
    input  logic [SIZE_W-1:0] size_sel,
    output logic [DATA_W-1:0] keep_mask,
    output logic [DATA_W-1:0] top_bit
);
    logic [DATA_W-1:0] mask_tab [NSIZES];
    logic [DATA_W-1:0] top_tab  [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int W = 8 << g;
        if (W >= DATA_W) begin : g_full
            assign mask_tab[g] = '1;
        end else begin : g_part
            assign mask_tab[g] = {{(DATA_W-W){1'b0}}, {W{1'b1}}};
        end
        assign top_tab[g] = DATA_W'(1) << (W - 1);
    end

    always_comb begin
        keep_mask = mask_tab[size_sel];
        top_bit   = top_tab[size_sel];
    end
endmodule

// File: rtl/dec_flag_gen.sv
module dec_flag_gen
    import dec_pkg::*;
(
    input  logic [DATA_W-1:0] opnd_m,
    input  logic [DATA_W-1:0] res_m,
    input  logic [DATA_W-1:0] top_bit,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out
);
    always_comb begin
        flags_out           = flags_in;
        flags_out[FB_OVF]   = (opnd_m == top_bit);
        flags_out[FB_SIGN]  = |(res_m & top_bit);
        flags_out[FB_ZERO]  = (res_m == '0);
        flags_out[FB_AUX]   = (opnd_m[3:0] == 4'h0);
        flags_out[FB_PAR]   = ~^res_m[7:0];
    end
endmodule

// File: rtl/dec_unit.sv
module dec_unit
    import dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        size_sel,
    input  logic [63:0]       operand,
    input  logic [15:0]       flags_in,
    output logic              out_valid,
    output logic [63:0]       result,
    output logic [15:0]       flags_out
);
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] top_bit;
    logic [DATA_W-1:0] opnd_m;
    logic [DATA_W-1:0] res_m;
    logic [FLAG_W-1:0] flg_new;
    dec_stage_t        stage_d, stage_q;

    dec_width_mask u_mask (
        .size_sel  (size_sel),
        .keep_mask (keep_mask),
        .top_bit   (top_bit)
    );

    always_comb begin
        opnd_m = operand & keep_mask;
        res_m  = (opnd_m - DATA_W'(1)) & keep_mask;
    end

    dec_flag_gen u_flags (
        .opnd_m    (opnd_m),
        .res_m     (res_m),
        .top_bit   (top_bit),
        .flags_in  (flags_in),
        .flags_out (flg_new)
    );

    always_comb begin
        stage_d.vld = in_valid;
        stage_d.res = res_m;
        stage_d.flg = flg_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;
    assign flags_out = stage_q.flg;

    // R10: strobe delayed by one cycle
    assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2: carry untouched
    assert_carry_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n)) |-> (flags_out[FB_CARRY] == $past(flags_in[FB_CARRY])));

    // R9: unrelated flag bits pass through
    assert_other_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n)) |->
            ((flags_out & ~FLAG_RECALC) == ($past(flags_in) & ~FLAG_RECALC)));

    // R6: aux carry from operand low nibble
    assert_aux_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n)) |-> (flags_out[FB_AUX] == ($past(operand[3:0]) == 4'h0)));

    // R7: parity over low byte of result
    assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_out[FB_PAR] == ~^result[7:0]));

    // R5: zero flag matches a zero result
    assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_out[FB_ZERO] == (result == 64'd0)));

    // R8: upper result bits cleared at narrow widths
    assert_upper_clear8_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n) && $past(size_sel) == 2'b00) |-> (result[63:8] == '0));
    assert_upper_clear16_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n) && $past(size_sel) == 2'b01) |-> (result[63:16] == '0));
endmodule

// File: tb/tb_dec_unit.sv
`timescale 1ns/1ps
module tb_dec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  size_sel = 2'b00;
    logic [63:0] operand = '0;
    logic [15:0] flags_in = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [15:0] flags_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
        .operand(operand), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .flags_out(flags_out)
    );

    typedef struct { logic v; logic [63:0] r; logic [15:0] f; } exp_t;
    exp_t expq[$];
    logic [63:0] lfsr = 64'hACE1_2468_1357_BDF0;

    function automatic logic [63:0] nxt(logic [63:0] s);
        return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
    endfunction

    function automatic exp_t model(logic v, logic [1:0] sz, logic [63:0] op, logic [15:0] fi);
        exp_t e;
        int w;
        logic [63:0] m, o, r;
        int ones;
        w = 8 << sz;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        o = op & m;
        r = (o - 64'd1) & m;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        e.v = v;
        e.r = r;
        e.f = fi;
        e.f[11] = (o == (64'd1 << (w - 1)));
        e.f[7]  = r[w-1];
        e.f[6]  = (o == 64'd1);
        e.f[4]  = (o % 16 == 0);
        e.f[2]  = (ones % 2 == 0);
        return e;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare at negedge, then drive next input
    task automatic step(logic v, logic [1:0] sz, logic [63:0] op, logic [15:0] fi);
        exp_t e;
        @(negedge clk);
        if (expq.size() > 0) begin
            e = expq.pop_front();
            chk(out_valid == e.v, "R10 valid", 64'(out_valid), 64'(e.v));
            chk(result == e.r, "R1/R8 result", result, e.r);
            chk(flags_out[0] == e.f[0], "R2 carry", 64'(flags_out[0]), 64'(e.f[0]));
            chk(flags_out[11] == e.f[11], "R3 overflow", 64'(flags_out[11]), 64'(e.f[11]));
            chk(flags_out[7] == e.f[7], "R4 sign", 64'(flags_out[7]), 64'(e.f[7]));
            chk(flags_out[6] == e.f[6], "R5 zero", 64'(flags_out[6]), 64'(e.f[6]));
            chk(flags_out[4] == e.f[4], "R6 aux", 64'(flags_out[4]), 64'(e.f[4]));
            chk(flags_out[2] == e.f[2], "R7 parity", 64'(flags_out[2]), 64'(e.f[2]));
            chk(flags_out == e.f, "R9 flag word", 64'(flags_out), 64'(e.f));
        end
        in_valid = v; size_sel = sz; operand = op; flags_in = fi;
        expq.push_back(model(v, sz, op, fi));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] pats [7];
        in_valid = 1'b1; operand = 64'h1; flags_in = '1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10 reset valid", 64'(out_valid), 64'd0);
        chk(result == 64'd0, "R10 reset result", result, 64'd0);
        chk(flags_out == 16'd0, "R10 reset flags", 64'(flags_out), 64'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        for (int s = 0; s < 4; s++) begin
            int w;
            logic [63:0] m;
            w = 8 << s;
            m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            pats[0] = 64'd0; pats[1] = 64'd1; pats[2] = 64'd2;
            pats[3] = 64'd1 << (w - 1); pats[4] = (64'd1 << (w - 1)) - 64'd1;
            pats[5] = m; pats[6] = 64'h10;
            for (int p = 0; p < 7; p++) begin
                // R8: clean and dirty upper bits; R2/R9: all-ones and random flags
                step(1'b1, 2'(s), pats[p], 16'hFFFF);
                step(1'b1, 2'(s), pats[p], 16'h0000);
                lfsr = nxt(lfsr);
                step(1'b1, 2'(s), pats[p] | (lfsr & ~m), lfsr[15:0]);
            end
        end
        for (int k = 0; k < 3000; k++) begin
            lfsr = nxt(lfsr);
            step(lfsr[40] | lfsr[41], lfsr[50:49], lfsr, lfsr[31:16] ^ lfsr[15:0]);
        end
        step(1'b0, 2'b00, 64'd0, 16'd0);
        step(1'b0, 2'b00, 64'd0, 16'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule